// File: doc/BRIEF.md
# Debug Monitor Security Unlock Gate

This block decides whether a host attached to the debug monitor may read on-chip program memory and run code from it. After a power-on reset, and once the monitor mode indication is high, the gate collects eight bytes from a byte-receive strobe interface. The serial bit receiver that feeds this interface sits outside the block. The gate compares the bytes in arrival order against a stored 64-bit key. When all eight match, it raises a bypass level that the memory access logic uses as its permission.

The gate reads all eight bytes even when an early byte has already failed. It gives no sign of which byte was wrong. After the eighth byte it pulses `done` for one cycle and closes its window: later bytes change nothing until the next power-on reset. A warm reset restarts the state machine, but the bypass level keeps its value. The window also stays shut after a warm reset, so no new key entry is needed or accepted. Only the power-on reset input clears the bypass.

The state machine has four states:
- `S_IDLE`: the state after either reset.
  - It moves to `S_COLLECT` when entry is still allowed and `mon_mode` is high.
  - It moves to `S_CLOSED` when entry is no longer allowed (after a warm reset).
- `S_COLLECT`: counts accepted bytes and keeps a sticky mismatch flag. It moves to `S_REPORT` on the eighth byte.
- `S_REPORT`: drives `done` and moves to `S_CLOSED` on the next cycle.
- `S_CLOSED`: absorbing until a reset.

Top module: `monitor_unlock_gate`

## Requirements
- R1: Received byte number i, counting from 0, is compared against `key_vec[8*i+7:8*i]`. This is the key byte stored at address $FFF6+i. Bytes are taken in arrival order, and a byte is accepted on a rising clock edge where `byte_valid` is high.
- R2: If all eight accepted bytes match their key bytes, `bypass` is 1 from the edge that accepts the eighth byte onward.
- R3: If any of the eight bytes mismatches, wherever it falls, `bypass` stays 0. `done` rises only after the eighth byte, never earlier.
- R4: `done` is high for exactly one cycle, in the cycle following the edge that accepts the eighth byte.
- R5: After `done`, further bytes cause no new `done` and do not change `bypass` until the next power-on reset.
- R6: Once `bypass` is 1 it stays 1 until `por_n` goes low. `por_n` low clears `bypass` and the byte count at once.
- R7: A synchronous warm reset (`wrst` high at an edge) leaves `bypass` unchanged and discards any partial entry. Until the next power-on reset, bytes afterwards cause no `done` and do not change `bypass`.
- R8: Bytes are accepted only while the gate is collecting, which starts the cycle after `mon_mode` is seen high following a power-on reset. Bytes sent while `mon_mode` is low are ignored.
- R9: Right after a power-on reset, `bypass` is 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| wrst | input | 1 | Warm reset, synchronous, active high |
| mon_mode | input | 1 | Monitor mode entry indication |
| byte_valid | input | 1 | Strobe: `byte_data` holds a received byte |
| byte_data | input | 8 | Received security byte |
| key_vec | input | 64 | Key bytes; byte i in bits [8i+7:8i] |
| done | output | 1 | One-cycle pulse when the eight-byte comparison ends |
| bypass | output | 1 | Security bypass level |

## Verification
Several internal faults show up on the outputs one clock after the eighth byte:
- A wrong byte count makes `done` appear early, late or not at all.
- A lost mismatch flag raises `bypass` for a key that was wrong in a single position.

A fault in the window or warm-reset handling shows up as an unexpected extra `done` pulse, or a changed `bypass`, within one cycle of the eighth byte sent after closure. A `bypass` register that reacts to the wrong reset shows up on the first sample taken after a warm or power-on reset.

// File: rtl/unlock_gate_pkg.sv
package unlock_gate_pkg;
    localparam int KEY_BYTES = 8;
    localparam int BYTE_W    = 8;

    typedef enum logic [1:0] {
        S_IDLE,
        S_COLLECT,
        S_REPORT,
        S_CLOSED
    } gate_state_t;
endpackage

// File: rtl/key_byte_compare.sv
module key_byte_compare #(
    parameter int KEY_BYTES = 8,
    parameter int BYTE_W    = 8,
    localparam int IDX_W    = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1
) (
    input  logic [KEY_BYTES*BYTE_W-1:0] key_vec,
    input  logic [IDX_W-1:0]            idx,
    input  logic [BYTE_W-1:0]           rx_byte,
    output logic                        match
);
    logic [BYTE_W-1:0] key_arr [KEY_BYTES];

    // Slice the key vector into bytes: lowest byte is the lowest address.
    for (genvar g = 0; g < KEY_BYTES; g++) begin : g_slice
        assign key_arr[g] = key_vec[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        match = 1'b0;
        for (int i = 0; i < KEY_BYTES; i++) begin
            if (idx == IDX_W'(i)) begin
                match = (rx_byte == key_arr[i]);
            end
        end
    end
endmodule

// File: rtl/unlock_entry_fsm.sv
module unlock_entry_fsm
    import unlock_gate_pkg::*;
#(
    parameter int KEY_BYTES = 8,
    localparam int IDX_W    = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             wrst,
    input  logic             mon_mode,
    input  logic             byte_valid,
    input  logic             byte_match,
    output logic [IDX_W-1:0] byte_idx,
    output logic             done,
    output logic             unlock_set
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(KEY_BYTES - 1);

    gate_state_t      st_q, st_nx;
    logic [IDX_W-1:0] cnt_q, cnt_nx;
    logic             miss_q, miss_nx;
    logic             allow_q;   // entry still permitted since power-on

    // State register: power-on clears everything, warm reset closes entry.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q    <= S_IDLE;
            cnt_q   <= '0;
            miss_q  <= 1'b0;
            allow_q <= 1'b1;
        end else if (wrst) begin
            st_q    <= S_IDLE;
            cnt_q   <= '0;
            miss_q  <= 1'b0;
            allow_q <= 1'b0;
        end else begin
            st_q    <= st_nx;
            cnt_q   <= cnt_nx;
            miss_q  <= miss_nx;
        end
    end

    // Transitions.
    always_comb begin
        st_nx   = st_q;
        cnt_nx  = cnt_q;
        miss_nx = miss_q;
        unique case (st_q)
            S_IDLE: begin
                if (!allow_q) begin
                    st_nx = S_CLOSED;
                end else if (mon_mode) begin
                    st_nx = S_COLLECT;
                end
            end
            S_COLLECT: begin
                if (byte_valid) begin
                    cnt_nx  = cnt_q + IDX_W'(1);
                    miss_nx = miss_q | ~byte_match;
                    if (cnt_q == LAST_IDX) begin
                        st_nx = S_REPORT;
                    end
                end
            end
            S_REPORT: st_nx = S_CLOSED;
            S_CLOSED: st_nx = S_CLOSED;
            default:  st_nx = S_CLOSED;
        endcase
    end

    // Outputs.
    always_comb begin
        byte_idx   = cnt_q;
        done       = (st_q == S_REPORT);
        unlock_set = (st_q == S_COLLECT) && byte_valid && (cnt_q == LAST_IDX)
                     && !miss_q && byte_match;
    end
endmodule

// File: rtl/bypass_hold.sv
module bypass_hold (
    input  logic clk,
    input  logic por_n,
    input  logic set,
    output logic bypass
);
    // Only a power-on reset clears the flag; warm reset is not an input.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            bypass <= 1'b0;
        end else if (set) begin
            bypass <= 1'b1;
        end
    end
endmodule

// File: rtl/monitor_unlock_gate.sv
module monitor_unlock_gate
    import unlock_gate_pkg::*;
#(
    parameter int KEY_BYTES = unlock_gate_pkg::KEY_BYTES,
    parameter int BYTE_W    = unlock_gate_pkg::BYTE_W,
    localparam int IDX_W    = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1
) (
    input  logic                        clk,
    input  logic                        por_n,
    input  logic                        wrst,
    input  logic                        mon_mode,
    input  logic                        byte_valid,
    input  logic [BYTE_W-1:0]           byte_data,
    input  logic [KEY_BYTES*BYTE_W-1:0] key_vec,
    output logic                        done,
    output logic                        bypass
);
    logic [IDX_W-1:0] byte_idx;
    logic             byte_match;
    logic             unlock_set;

    key_byte_compare #(
        .KEY_BYTES (KEY_BYTES),
        .BYTE_W    (BYTE_W)
    ) u_cmp (
        .key_vec (key_vec),
        .idx     (byte_idx),
        .rx_byte (byte_data),
        .match   (byte_match)
    );

    unlock_entry_fsm #(
        .KEY_BYTES (KEY_BYTES)
    ) u_fsm (
        .clk        (clk),
        .por_n      (por_n),
        .wrst       (wrst),
        .mon_mode   (mon_mode),
        .byte_valid (byte_valid),
        .byte_match (byte_match),
        .byte_idx   (byte_idx),
        .done       (done),
        .unlock_set (unlock_set)
    );

    bypass_hold u_hold (
        .clk    (clk),
        .por_n  (por_n),
        .set    (unlock_set),
        .bypass (bypass)
    );
endmodule

// File: rtl/monitor_unlock_gate_chk.sv
module monitor_unlock_gate_chk (
    input logic clk,
    input logic por_n,
    input logic wrst,
    input logic done,
    input logic bypass
);
    logic fired_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            fired_q <= 1'b0;
        end else if (done) begin
            fired_q <= 1'b1;
        end
    end

    // R4: done lasts a single cycle
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!por_n)
        done |=> !done);

    // R6: bypass never drops without a power-on reset
    a_r6_bypass_sticky: assert property (@(posedge clk) disable iff (!por_n)
        bypass |=> bypass);

    // R2: bypass appears together with the completion pulse
    a_r2_rise_with_done: assert property (@(posedge clk) disable iff (!por_n)
        $rose(bypass) |-> done);

    // R5: at most one completion per power-on
    a_r5_single_done: assert property (@(posedge clk) disable iff (!por_n)
        fired_q |-> !done);

    // R7: a warm reset is never followed by a completion pulse
    a_r7_warm_no_done: assert property (@(posedge clk) disable iff (!por_n)
        wrst |=> !done);
endmodule

bind monitor_unlock_gate monitor_unlock_gate_chk u_chk (
    .clk    (clk),
    .por_n  (por_n),
    .wrst   (wrst),
    .done   (done),
    .bypass (bypass)
);

// File: tb/monitor_unlock_gate_tb.sv
module monitor_unlock_gate_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] KEY = 64'h5A_C3_19_E7_42_8D_F0_36;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        wrst = 1'b0;
    logic        mon_mode = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        done;
    logic        bypass;

    int tests = 0;
    int fails = 0;
    int done_count = 0;
    bit finished = 1'b0;
    bit exp_q [$];
    logic prev_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    monitor_unlock_gate u_dut (
        .clk        (clk),
        .por_n      (por_n),
        .wrst       (wrst),
        .mon_mode   (mon_mode),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .key_vec    (KEY),
        .done       (done),
        .bypass     (bypass)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected bypass value at each completion pulse.
    always @(negedge clk) begin
        if (por_n) begin
            if (done && prev_done) check(1'b0, "R4 done longer than one cycle", 1, 0);
            if (done && !prev_done) begin
                done_count++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5/R7/R8 unexpected done", 1, 0);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    check(bypass == e, "R2/R3 bypass at done", int'(bypass), int'(e));
                end
            end
        end
        prev_done = done;
    end

    function automatic logic [7:0] key_byte(input int i);
        return KEY[8*i +: 8];
    endfunction

    task automatic power_on();
        @(negedge clk);
        por_n = 1'b0;
        mon_mode = 1'b0;
        byte_valid = 1'b0;
        exp_q.delete();
        repeat (2) @(negedge clk);
        por_n = 1'b1;
    endtask

    task automatic warm_reset();
        @(negedge clk);
        wrst = 1'b1;
        @(negedge clk);
        wrst = 1'b0;
    endtask

    task automatic enter_monitor();
        @(negedge clk);
        mon_mode = 1'b1;
        @(negedge clk);
    endtask

    // Driver: bad_pos < 0 means the correct key; gap inserts idle cycles.
    task automatic send_key(input int bad_pos, input int gap, input bit expect_done);
        if (expect_done) exp_q.push_back(bad_pos < 0);
        for (int i = 0; i < 8; i++) begin
            byte_valid = 1'b1;
            byte_data = (i == bad_pos) ? (key_byte(i) ^ 8'h01) : key_byte(i);
            @(negedge clk);
            byte_valid = 1'b0;
            for (int k = 0; k < gap; k++) @(negedge clk);
        end
        byte_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int dc;
        power_on();
        @(negedge clk);
        check(bypass == 1'b0, "R9 bypass after power-on", int'(bypass), 0);
        check(done == 1'b0, "R9 done after power-on", int'(done), 0);

        // R8: bytes with monitor mode low are ignored
        dc = done_count;
        send_key(-1, 0, 1'b0);
        check(done_count == dc, "R8 no done with mon_mode low", done_count, dc);
        check(bypass == 1'b0, "R8 bypass with mon_mode low", int'(bypass), 0);

        // R1/R2: correct key in address order, after mon_mode rises
        enter_monitor();
        dc = done_count;
        send_key(-1, 0, 1'b1);
        check(done_count == dc + 1, "R2 one done after correct key", done_count, dc + 1);
        check(bypass == 1'b1, "R2 bypass after correct key", int'(bypass), 1);

        // R7: warm reset keeps bypass, no entry needed or accepted
        warm_reset();
        @(negedge clk);
        check(bypass == 1'b1, "R7 bypass kept over warm reset", int'(bypass), 1);
        dc = done_count;
        send_key(3, 0, 1'b0);
        check(done_count == dc, "R7 bytes ignored after warm reset", done_count, dc);
        check(bypass == 1'b1, "R7 bypass after ignored bytes", int'(bypass), 1);

        // R6: power-on reset clears bypass
        power_on();
        @(negedge clk);
        check(bypass == 1'b0, "R6 power-on clears bypass", int'(bypass), 0);

        // R3: mismatch in the middle, then R5: window closed
        enter_monitor();
        send_key(3, 0, 1'b1);
        check(bypass == 1'b0, "R3 mid mismatch locked", int'(bypass), 0);
        dc = done_count;
        send_key(-1, 0, 1'b0);
        check(done_count == dc, "R5 no done after window closed", done_count, dc);
        check(bypass == 1'b0, "R5 bypass after window closed", int'(bypass), 0);

        // R3: mismatch in the first byte, done only after eighth byte
        power_on();
        enter_monitor();
        exp_q.push_back(1'b0);
        for (int i = 0; i < 8; i++) begin
            byte_valid = 1'b1;
            byte_data = (i == 0) ? ~key_byte(0) : key_byte(i);
            @(negedge clk);
            if (i < 7) check(done == 1'b0, "R3 no early done", int'(done), 0);
        end
        byte_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(bypass == 1'b0, "R3 first-byte mismatch locked", int'(bypass), 0);

        // R3: mismatch in last byte only
        power_on();
        enter_monitor();
        send_key(7, 0, 1'b1);
        check(bypass == 1'b0, "R3 last-byte mismatch locked", int'(bypass), 0);

        // R1: key supplied in reversed byte order must fail
        power_on();
        enter_monitor();
        exp_q.push_back(1'b0);
        for (int i = 0; i < 8; i++) begin
            byte_valid = 1'b1;
            byte_data = key_byte(7 - i);
            @(negedge clk);
        end
        byte_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(bypass == 1'b0, "R1 reversed order locked", int'(bypass), 0);

        // R4: done timing, correct key with gaps between bytes
        power_on();
        enter_monitor();
        exp_q.push_back(1'b1);
        for (int i = 0; i < 8; i++) begin
            byte_valid = 1'b1;
            byte_data = key_byte(i);
            @(negedge clk);
            byte_valid = 1'b0;
            if (i < 7) begin
                repeat (2) @(negedge clk);
            end
        end
        check(done == 1'b1, "R4 done the cycle after eighth byte", int'(done), 1);
        @(negedge clk);
        check(done == 1'b0, "R4 done drops next cycle", int'(done), 0);
        check(bypass == 1'b1, "R2 bypass with gapped bytes", int'(bypass), 1);

        // R7: warm reset during partial entry closes the window
        power_on();
        enter_monitor();
        for (int i = 0; i < 4; i++) begin
            byte_valid = 1'b1;
            byte_data = key_byte(i);
            @(negedge clk);
        end
        byte_valid = 1'b0;
        warm_reset();
        repeat (2) @(negedge clk);
        dc = done_count;
        send_key(-1, 0, 1'b0);
        check(done_count == dc, "R7 no entry after warm reset", done_count, dc);
        check(bypass == 1'b0, "R7 stays locked after warm reset", int'(bypass), 0);

        check(exp_q.size() == 0, "R4 all expected completions seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule